// File: doc/BRIEF.md
# Prescaled Up-Counting Timer Time Base

This block is the counting core of a general purpose timer. It runs on the system clock. A prescaler divides that clock by a power of two, from 1 up to 32768, and so makes a count tick. A 16-bit up counter advances on each tick. When the counter reaches the active auto-reload value, the next tick returns it to zero and raises an update event. Every update event also sets a sticky interrupt flag.

Software reaches the block through a small register port. The prescaler setting and the auto-reload value are written into preload registers. Those values are copied into working (shadow) registers only on an update event. A control bit decides whether the auto-reload value waits for that copy or takes effect at once. An enable pin gates both the prescaler and the counter. A strobe pin forces an update event, which restarts the count and loads the shadows.

The register port is plain control access with no data stream. A write is taken in the cycle that `reg_wr` is high. Reads are combinational from `reg_addr`. No back-pressure exists on any pin.

Top module: `tbu_timebase`

## Requirements
- R1: After reset, the following values hold: counter 0, prescaler preload and shadow 0, auto-reload preload and shadow 0xFFFF, control bit0 0, and interrupt flag 0.
- R2: With working prescaler value p, the counter advances exactly once every 2^p enabled clock cycles, for p from 0 to 15.
- R3: When a tick finds the counter equal to the active auto-reload value, `update_evt` is high in that cycle and the counter is 0 after the clock edge. Otherwise a tick adds one to the counter.
- R4: If the counter is above the auto-reload value, it keeps counting up to 0xFFFF. A tick at 0xFFFF then wraps it to 0 and raises an update event.
- R5: While `cnt_en` is low, neither the prescaler nor the counter changes, apart from updates forced by the strobe or by a write.
- R6: A high `ug_strobe` raises `update_evt` in the same cycle, whatever the state of `cnt_en`. At the next edge it clears the counter and the prescaler and loads both shadow registers from their preloads.
- R7: A prescaler write changes only the preload. The counting rate changes only after the next update event.
- R8: With control bit0 = 1, an auto-reload write takes effect at the next update event. With bit0 = 0 it takes effect from the next cycle.
- R9: Every update event sets `irq_flag`. The flag stays set until a status write with bit0 = 0 clears it. A status write with bit0 = 1 has no effect. A set in the same cycle as a clear wins.
- R10: A counter write loads the written value at the next edge, and counting goes on from it. An update event in the same cycle takes precedence and the counter becomes 0.
- R11: The register map is as follows, with unused bits reading 0:
  - address 0: control, bit0 selects buffered auto-reload
  - address 1: prescaler preload, bits 3:0
  - address 2: auto-reload preload
  - address 3: counter
  - address 4: status, bit0 is the flag

  Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, used for both write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| cnt_en | input | 1 | Count enable for the prescaler and the counter |
| ug_strobe | input | 1 | Forces an update event |
| update_evt | output | 1 | High in each cycle that holds an update event |
| irq_flag | output | 1 | Sticky update interrupt flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a 4-bit prescaler field. Small auto-reload values and prescaler settings from 0 to 3 make wraps happen every few cycles, so the random phase crosses many update events, buffered auto-reload changes and races between write and event. One directed run uses the largest prescaler value (15, a ratio of 32768) with an auto-reload of 0 to confirm the full division ratio. Another preloads the counter at 0xFFFD above a small auto-reload, which brings the full-range wrap within a few ticks.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_PSC  = 3'd1,
    SEL_ARR  = 3'd2,
    SEL_CNT  = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/tbu_regs.sv
module tbu_regs
  import tbu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              uev,
  output logic [CNT_W-1:0]  rd_data,
  output logic [PSC_W-1:0]  psc_work,
  output logic [CNT_W-1:0]  arr_work,
  output logic              cnt_wr,
  output logic              flag
);
  logic             arr_buf;
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] arr_pre;
  logic [CNT_W-1:0] arr_sh;
  logic             clr_req;

  assign clr_req = wr_en && (addr == SEL_STAT) && !wr_data[0];
  assign cnt_wr  = wr_en && (addr == SEL_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_buf  <= 1'b0;
      psc_pre  <= '0;
      arr_pre  <= '1;
      psc_work <= '0;
      arr_sh   <= '1;
      flag     <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          SEL_CTRL: arr_buf <= wr_data[0];
          SEL_PSC:  psc_pre <= wr_data[PSC_W-1:0];
          SEL_ARR:  arr_pre <= wr_data;
          default:  ;
        endcase
      end
      if (uev) begin
        psc_work <= psc_pre;
        arr_sh   <= arr_pre;
      end
      if (uev)          flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end

  assign arr_work = arr_buf ? arr_sh : arr_pre;

  always_comb begin
    rd_data = '0;
    case (addr)
      SEL_CTRL: rd_data[0]         = arr_buf;
      SEL_PSC:  rd_data[PSC_W-1:0] = psc_pre;
      SEL_ARR:  rd_data            = arr_pre;
      SEL_CNT:  rd_data            = cnt_val;
      SEL_STAT: rd_data[0]         = flag;
      default:  rd_data            = '0;
    endcase
  end

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uev |=> flag);
  assert_flag_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag);
  assert_psc_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !uev |=> $stable(psc_work));
  assert_arr_buffered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_buf && !uev && !(wr_en && addr == SEL_CTRL)) |=> $stable(arr_work));
endmodule

// File: rtl/tbu_prescaler.sv
module tbu_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PSC_W-1:0] psc_work,
  output logic             tick
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] limit;

  for (genvar gi = 0; gi < DIV_W; gi++) begin : g_limit
    assign limit[gi] = (32'(psc_work) > gi);
  end

  assign tick = run && (pcnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)     pcnt <= '0;
    else if (clear) pcnt <= '0;
    else if (run)   pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  assert_pcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= limit);
  assert_psc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(pcnt));
  assert_psc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pcnt == '0));
endmodule

// File: rtl/tbu_counter.sv
module tbu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] arr_work,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign ovf = tick && ((cnt == arr_work) || (cnt == TOP));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (wr)    cnt <= wr_val;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && !wr) |=> (cnt == $past(cnt) + 1'b1));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear && !wr) |=> $stable(cnt));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clear) |=> (cnt == $past(wr_val)));
endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
  import tbu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cnt_en,
  input  logic              ug_strobe,
  output logic              update_evt,
  output logic              irq_flag
);
  logic [PSC_W-1:0] psc_work;
  logic [CNT_W-1:0] arr_work;
  logic [CNT_W-1:0] cnt;
  logic             cnt_wr;
  logic             tick;
  logic             ovf;
  logic             uev;

  assign uev        = ug_strobe || ovf;
  assign update_evt = uev;

  tbu_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wr_data(reg_wdata), .cnt_val(cnt), .uev(uev), .rd_data(reg_rdata),
    .psc_work(psc_work), .arr_work(arr_work), .cnt_wr(cnt_wr), .flag(irq_flag)
  );

  tbu_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(cnt_en), .clear(uev),
    .psc_work(psc_work), .tick(tick)
  );

  tbu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(uev), .wr(cnt_wr),
    .wr_val(reg_wdata), .arr_work(arr_work), .cnt(cnt), .ovf(ovf)
  );

  assert_strobe_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ug_strobe |-> update_evt);
  assert_idle_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ug_strobe) |-> !update_evt);
  assert_flag_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |=> irq_flag);
endmodule

// File: tb/sim_tbu_timebase.sv
`timescale 1ns/1ps
module sim_tbu_timebase;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        cnt_en;
  logic        ug_strobe;
  logic        update_evt;
  logic        irq_flag;

  always #2 clk = ~clk;

  tbu_timebase u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_en(cnt_en),
    .ug_strobe(ug_strobe), .update_evt(update_evt), .irq_flag(irq_flag)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    pulses;
  string cur_req = "R1";

  // Model state derived from the requirements
  logic [15:0] m_cnt, m_arr_pre, m_arr_sh;
  logic [14:0] m_pcnt;
  logic [3:0]  m_psc_pre, m_psc_sh;
  logic        m_buf, m_flag;

  function automatic logic [14:0] lim(input logic [3:0] p);
    return 15'((32'd1 << p) - 1);
  endfunction

  function automatic logic [15:0] act_arr();
    return m_buf ? m_arr_sh : m_arr_pre;
  endfunction

  function automatic logic m_event(input logic en, input logic ug);
    logic tk;
    tk = en && (m_pcnt == lim(m_psc_sh));
    return ug || (tk && (m_cnt == act_arr() || m_cnt == 16'hFFFF));
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {15'd0, m_buf};
      3'd1: return {12'd0, m_psc_pre};
      3'd2: return m_arr_pre;
      3'd3: return m_cnt;
      3'd4: return {15'd0, m_flag};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, advance model at posedge
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [15:0] d,
                     input logic en, input logic ug);
    logic ev, tk, clr;
    reg_wr = wr; reg_addr = a; reg_wdata = d; cnt_en = en; ug_strobe = ug;
    #1;
    ev = m_event(en, ug);
    tk = en && (m_pcnt == lim(m_psc_sh));
    chk({15'd0, update_evt}, {15'd0, ev}, "update_evt");
    chk({15'd0, irq_flag}, {15'd0, m_flag}, "irq_flag");
    chk(reg_rdata, m_read(a), "reg_rdata");
    if (ev) pulses++;
    @(posedge clk);
    clr = wr && a == 3'd4 && !d[0];
    if (ev) begin
      m_cnt = 16'd0; m_pcnt = 15'd0;
      m_psc_sh = m_psc_pre; m_arr_sh = m_arr_pre;
    end else begin
      if (en) m_pcnt = tk ? 15'd0 : m_pcnt + 15'd1;
      if (wr && a == 3'd3) m_cnt = d;
      else if (tk) m_cnt = m_cnt + 16'd1;
    end
    if (ev) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (wr) case (a)
      3'd0: m_buf = d[0];
      3'd1: m_psc_pre = d[3:0];
      3'd2: m_arr_pre = d;
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic en, input logic [2:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 16'd0, en, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; cnt_en = 0; ug_strobe = 0;
    m_cnt = 0; m_pcnt = 0; m_psc_pre = 0; m_psc_sh = 0;
    m_arr_pre = 16'hFFFF; m_arr_sh = 16'hFFFF; m_buf = 0; m_flag = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 and R11: reset values through the register map
    cur_req = "R1";
    for (int a = 0; a < 8; a++) idle(1, 1'b0, 3'(a));
    cur_req = "R11";
    cyc(1, 3'd0, 16'hFFFE, 0, 0); idle(1, 0, 3'd0);
    cyc(1, 3'd1, 16'hFFF5, 0, 0); idle(1, 0, 3'd1);

    // R3: unbuffered auto-reload of 3, divide by 1
    cur_req = "R3";
    cyc(1, 3'd1, 16'd0, 0, 0);
    cyc(1, 3'd2, 16'd3, 0, 0);
    cyc(0, 3'd3, 16'd0, 0, 1);
    idle(12, 1, 3'd3);

    // R2: prescaler 2, reload 3 -> one update every 16 cycles
    cur_req = "R2";
    cyc(1, 3'd1, 16'd2, 1, 0);
    cyc(0, 3'd3, 16'd0, 1, 1);
    pulses = 0;
    idle(64, 1, 3'd3);
    chk(16'(pulses), 16'd4, "update count over 64 cycles");

    // R7: new prescaler waits for the next event
    cur_req = "R7";
    cyc(1, 3'd1, 16'd0, 1, 0);
    idle(20, 1, 3'd3);

    // R5: hold while disabled
    cur_req = "R5";
    idle(20, 0, 3'd3);
    idle(5, 1, 3'd3);

    // R8: buffered vs immediate auto-reload
    cur_req = "R8";
    cyc(1, 3'd0, 16'd1, 1, 0);
    cyc(1, 3'd2, 16'd7, 1, 0);
    idle(25, 1, 3'd3);
    cyc(1, 3'd0, 16'd0, 1, 0);
    cyc(1, 3'd2, 16'd2, 1, 0);
    idle(10, 1, 3'd3);

    // R10: counter write, and event precedence over write
    cur_req = "R10";
    cyc(1, 3'd3, 16'h0001, 0, 0);
    idle(2, 0, 3'd3);
    cyc(1, 3'd3, 16'h0055, 0, 1);
    idle(2, 1, 3'd3);

    // R4: above reload, wrap at full range
    cur_req = "R4";
    cyc(1, 3'd2, 16'd5, 0, 0);
    cyc(1, 3'd3, 16'hFFFD, 0, 0);
    pulses = 0;
    idle(3, 1, 3'd3);
    chk(16'(pulses), 16'd1, "wrap at 0xFFFF");
    idle(3, 1, 3'd3);

    // R9: flag clear rules
    cur_req = "R9";
    cyc(1, 3'd4, 16'd1, 0, 0); idle(1, 0, 3'd4);
    cyc(1, 3'd4, 16'd0, 0, 0); idle(1, 0, 3'd4);
    cyc(1, 3'd4, 16'd0, 0, 1); idle(1, 0, 3'd4);

    // R6: strobe while disabled loads shadows
    cur_req = "R6";
    cyc(1, 3'd1, 16'd15, 0, 0);
    cyc(1, 3'd2, 16'd0, 0, 0);
    cyc(0, 3'd3, 16'd0, 0, 1);
    idle(2, 0, 3'd3);

    // R2: largest ratio, 32768 cycles per tick
    cur_req = "R2";
    cyc(0, 3'd3, 16'd0, 0, 1);
    pulses = 0;
    idle(32768, 1, 3'd3);
    chk(16'(pulses), 16'd1, "update count at ratio 32768");

    // Random mix
    cur_req = "R3";
    void'($urandom(32'd1234));
    cyc(1, 3'd1, 16'd0, 0, 0);
    cyc(0, 3'd3, 16'd0, 0, 1);
    for (int i = 0; i < 5000; i++) begin
      logic [2:0] a; logic [15:0] d; logic wr;
      a  = 3'($urandom_range(0, 5));
      wr = ($urandom_range(0, 9) == 0);
      case (a)
        3'd1: d = 16'($urandom_range(0, 3));
        3'd2: d = 16'($urandom_range(0, 20));
        3'd3: d = 16'($urandom_range(0, 24));
        default: d = 16'($urandom);
      endcase
      cyc(wr, a, d, $urandom_range(0, 7) != 0, $urandom_range(0, 63) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule